// File: doc/BRIEF.md
# Codec-Side Serial Audio Link Frame Interface

This block sits at the codec end of a five-wire serial audio link. It divides the master clock by two to make the bit clock, finds the frame boundary from the controller's frame marker, and splits each incoming 256-bit frame into a tag, a command slot, a data slot and audio slots. Register writes that the tag qualifies come out on a one-cycle parallel port. Received audio samples appear on parallel outputs once per frame. A frame carrying the local sample pair is shifted back toward the controller.

Everything runs in the master clock domain. The bit clock is a register that toggles on each master clock edge. A "falling" bit-clock edge is the master clock edge at which it goes from high to low, and a "rising" edge is the reverse. A write to the power register with the link-down bit set stops the bit clock right after the command data slot of that frame. A pulse on the frame marker then revives the link while the clock is stopped. The synchronous reset acts as a cold reset.

Top module: `aclink_codec`

## Requirements
- R1: While `rst` is high, `bclk_o`, `sdi_o` and `reg_wr_o` are 0 and both received sample outputs are 0.
- R2: Outside reset and link-down, `bclk_o` inverts on every `clk` edge, which is half the master clock rate.
- R3: `sync_i` and `sdo_i` are sampled on falling bit-clock edges. A sampled `sync_i` rising marks frame bit 0. The frame is sent MSB first and is laid out as a 16-bit tag at bits 0..15, followed by 20-bit slots (slot n starts at bit 16+20(n-1)). When tag bits 15, 14 and 13 are all 1 and slot 1 bit 19 is 0, `reg_wr_o` pulses for one cycle at the falling edge of frame bit 55. `reg_addr_o` is then slot 1 bits 18..12 and `reg_data_o` is slot 2 bits 19..4.
- R4: No write is made when tag bit 14 (slot 1 valid) is 0, or when slot 1 bit 19 is 1 (a read).
- R5: Slot 3 bits 19..4 and slot 4 bits 19..4 are staged during the frame. They are copied to `pcm_l_o` and `pcm_r_o` at the falling edge of frame bit 255, but only if tag bit 12 (slot 3) or tag bit 11 (slot 4) respectively is 1. Otherwise that output keeps its value.
- R6: `sdi_o` changes only on rising bit-clock edges and lags by one bit. Output bit k is driven on the rising edge after input bit k is sampled. The outgoing frame has tag 0x9800 (ready, slot 3 valid, slot 4 valid), zero slots 1 and 2, `pcm_l_i` in slot 3 bits 19..4 and `pcm_r_i` in slot 4 bits 19..4, with the remaining bits 0.
- R7: A write to address 0x20 with data bit 12 set stops the link. From the next `clk` edge, `bclk_o` and `sdi_o` stay 0, so no rising edge follows bit 55. A write to 0x20 with bit 12 clear leaves the link running.
- R8: While the link is down, `sync_i` is watched on `clk`. A high pulse on `sync_i` keeps `bclk_o` low while it is high, restarts `bclk_o` once it falls, and decoding resumes at the next frame marker.
- R9: A cold reset in the middle of a frame clears all state. After release, the next full frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high cold reset |
| sync_i | input | 1 | frame marker from the controller |
| sdo_i | input | 1 | serial frame from the controller |
| bclk_o | output | 1 | bit clock, master clock divided by two |
| sdi_o | output | 1 | serial frame toward the controller |
| reg_wr_o | output | 1 | one-cycle register write strobe |
| reg_addr_o | output | 7 | register write index |
| reg_data_o | output | 16 | register write data |
| pcm_l_o | output | 16 | received left sample |
| pcm_r_o | output | 16 | received right sample |
| pcm_l_i | input | 16 | left sample to send |
| pcm_r_i | input | 16 | right sample to send |

## Verification
The checker assumes that `sync_i` and `sdo_i` change only while `bclk_o` is low, so each bit is stable across the falling edge that samples it. It also assumes that reset is held for at least two cycles, and that a frame marker rises exactly at frame bit 0. The stimulus keeps to these rules by driving each bit right after it sees `bclk_o` low. It raises the marker for the first 16 bits of each frame and only pulses it freely while the bit clock is stopped. The power-down frame is cut off after bit 55, because no further bit-clock edges arrive.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int FRAME_BITS = 256;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int NSLOT      = (FRAME_BITS - TAG_W) / SLOT_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  // tag bit positions (the outgoing tag uses the same positions)
  localparam int TB_FRAME = 15;
  localparam int TB_S1    = 14;
  localparam int TB_S2    = 13;
  localparam int TB_S3    = 12;
  localparam int TB_S4    = 11;

  // index of the last bit of slot n (slot 0 is the tag)
  function automatic int slot_last(input int n);
    return TAG_W + SLOT_W * n - 1;
  endfunction

  // index of the first bit of slot n
  function automatic int slot_first(input int n);
    return (n == 0) ? 0 : TAG_W + SLOT_W * (n - 1);
  endfunction
endpackage

// File: rtl/aclink_bitclk.sv
module aclink_bitclk (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic pd_req,
  output logic bclk_o,
  output logic down_o,
  output logic fall_en,
  output logic rise_en
);
  logic bclk_q, down_q, sync_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      down_q <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_d <= sync_i;
      if (down_q) begin
        bclk_q <= 1'b0;
        if (sync_d && !sync_i) down_q <= 1'b0;
      end else if (pd_req) begin
        down_q <= 1'b1;
        bclk_q <= 1'b0;
      end else begin
        bclk_q <= ~bclk_q;
      end
    end
  end

  assign bclk_o  = bclk_q;
  assign down_o  = down_q;
  assign fall_en = bclk_q && !down_q;
  assign rise_en = !bclk_q && !down_q;
endmodule

// File: rtl/aclink_rx.sv
module aclink_rx
  import aclink_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_en,
  input  logic             down,
  input  logic             sync_i,
  input  logic             sdo_i,
  output logic             aligned_o,
  output logic [IDX_W-1:0] last_o,
  output logic             wr_o,
  output logic [AW-1:0]    addr_o,
  output logic [DW-1:0]    data_o,
  output logic [DW-1:0]    pcm_l_o,
  output logic [DW-1:0]    pcm_r_o
);
  localparam logic [IDX_W-1:0] L_TAG = IDX_W'(slot_last(0));
  localparam logic [IDX_W-1:0] L_S1  = IDX_W'(slot_last(1));
  localparam logic [IDX_W-1:0] L_S2  = IDX_W'(slot_last(2));
  localparam logic [IDX_W-1:0] L_S3  = IDX_W'(slot_last(3));
  localparam logic [IDX_W-1:0] L_S4  = IDX_W'(slot_last(4));
  localparam logic [IDX_W-1:0] L_END = IDX_W'(FRAME_BITS - 1);

  logic [SLOT_W-1:0] sh;
  logic [SLOT_W-1:0] word;
  logic [IDX_W-1:0]  nxt, cur;
  logic              sync_prev, start, aligned;
  logic [4:0]        tag;
  logic              cmd_rd;
  logic [AW-1:0]     cmd_addr;
  logic [DW-1:0]     stg_l, stg_r;
  logic              vl, vr;

  always_comb begin
    word  = {sh[SLOT_W-2:0], sdo_i};
    start = sync_i && !sync_prev;
    cur   = start ? '0 : nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; nxt <= '0; sync_prev <= 1'b0; aligned <= 1'b0;
      tag <= '0; cmd_rd <= 1'b0; cmd_addr <= '0;
      stg_l <= '0; stg_r <= '0; vl <= 1'b0; vr <= 1'b0;
      wr_o <= 1'b0; addr_o <= '0; data_o <= '0;
      pcm_l_o <= '0; pcm_r_o <= '0; last_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (down) begin
        aligned   <= 1'b0;
        sync_prev <= 1'b0;
      end else if (fall_en) begin
        sync_prev <= sync_i;
        sh        <= word;
        nxt       <= cur + 1'b1;
        last_o    <= cur;
        if (start) aligned <= 1'b1;
        if (aligned || start) begin
          if (cur == L_TAG) tag <= word[TB_FRAME:TB_S4];
          if (cur == L_S1) begin
            cmd_rd   <= word[SLOT_W-1];
            cmd_addr <= word[SLOT_W-2 -: AW];
          end
          if (cur == L_S2 && tag[4] && tag[3] && tag[2] && !cmd_rd) begin
            wr_o   <= 1'b1;
            addr_o <= cmd_addr;
            data_o <= word[SLOT_W-1 -: DW];
          end
          if (cur == L_S3) begin
            stg_l <= word[SLOT_W-1 -: DW];
            vl    <= tag[1];
          end
          if (cur == L_S4) begin
            stg_r <= word[SLOT_W-1 -: DW];
            vr    <= tag[0];
          end
          if (cur == L_END) begin
            if (vl) pcm_l_o <= stg_l;
            if (vr) pcm_r_o <= stg_r;
          end
        end
      end
    end
  end

  assign aligned_o = aligned;
endmodule

// File: rtl/aclink_tx.sv
module aclink_tx
  import aclink_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_en,
  input  logic             quiet,
  input  logic             aligned,
  input  logic [IDX_W-1:0] last,
  input  logic [DW-1:0]    pcm_l_i,
  input  logic [DW-1:0]    pcm_r_i,
  output logic             sdi_o
);
  localparam logic [TAG_W-1:0] TAG_OUT =
    TAG_W'((1 << TB_FRAME) | (1 << TB_S3) | (1 << TB_S4));
  localparam int PAD = SLOT_W - DW;

  logic [SLOT_W-1:0] sh, load;
  logic              at_start;

  always_comb begin
    at_start = 1'b0;
    load     = '0;
    for (int n = 0; n <= NSLOT; n++) begin
      if (last == IDX_W'(slot_first(n))) begin
        at_start = 1'b1;
        if (n == 0) load = {TAG_OUT, {(SLOT_W - TAG_W){1'b0}}};
        if (n == 3) load = {pcm_l_i, {PAD{1'b0}}};
        if (n == 4) load = {pcm_r_i, {PAD{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      sdi_o <= 1'b0;
    end else if (quiet) begin
      sdi_o <= 1'b0;
    end else if (rise_en) begin
      if (!aligned) begin
        sdi_o <= 1'b0;
      end else if (at_start) begin
        sdi_o <= load[SLOT_W-1];
        sh    <= {load[SLOT_W-2:0], 1'b0};
      end else begin
        sdi_o <= sh[SLOT_W-1];
        sh    <= {sh[SLOT_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/aclink_codec.sv
module aclink_codec
  import aclink_pkg::*;
#(
  parameter int            DW      = 16,
  parameter int            AW      = 7,
  parameter logic [AW-1:0] PD_ADDR = 7'h20,
  parameter int            PD_BIT  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  input  logic          sdo_i,
  output logic          bclk_o,
  output logic          sdi_o,
  output logic          reg_wr_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_data_o,
  output logic [DW-1:0] pcm_l_o,
  output logic [DW-1:0] pcm_r_o,
  input  logic [DW-1:0] pcm_l_i,
  input  logic [DW-1:0] pcm_r_i
);
  logic             link_down, fall_en, rise_en, pd_req, aligned;
  logic [IDX_W-1:0] last;

  assign pd_req = reg_wr_o && (reg_addr_o == PD_ADDR) && reg_data_o[PD_BIT];

  aclink_bitclk u_clk (
    .clk(clk), .rst(rst), .sync_i(sync_i), .pd_req(pd_req),
    .bclk_o(bclk_o), .down_o(link_down), .fall_en(fall_en), .rise_en(rise_en)
  );

  aclink_rx #(.DW(DW), .AW(AW)) u_rx (
    .clk(clk), .rst(rst), .fall_en(fall_en), .down(link_down),
    .sync_i(sync_i), .sdo_i(sdo_i), .aligned_o(aligned), .last_o(last),
    .wr_o(reg_wr_o), .addr_o(reg_addr_o), .data_o(reg_data_o),
    .pcm_l_o(pcm_l_o), .pcm_r_o(pcm_r_o)
  );

  aclink_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .rise_en(rise_en), .quiet(link_down || pd_req),
    .aligned(aligned), .last(last), .pcm_l_i(pcm_l_i), .pcm_r_i(pcm_r_i),
    .sdi_o(sdi_o)
  );
endmodule

// File: rtl/aclink_codec_chk.sv
module aclink_codec_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bclk,
  input logic          sdi,
  input logic          reg_wr,
  input logic          down,
  input logic [DW-1:0] pcm_l,
  input logic [DW-1:0] pcm_r
);
  // R2
  bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!down && !$past(down) && !$past(rst)) |-> (bclk != $past(bclk)));

  // R7
  link_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    down |-> (!bclk && !sdi));

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R3
  wr_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !$past(rst)) |-> $fell(bclk));

  // R6
  sdi_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdi) && !down && !$past(rst)) |-> $rose(bclk));

  // R5
  pcm_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ((!$stable(pcm_l) || !$stable(pcm_r)) && !$past(rst)) |-> $fell(bclk));
endmodule

bind aclink_codec aclink_codec_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bclk(bclk_o), .sdi(sdi_o), .reg_wr(reg_wr_o),
  .down(link_down), .pcm_l(pcm_l_o), .pcm_r(pcm_r_o)
);

// File: tb/aclink_codec_bench.sv
module aclink_codec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_i = 1'b0, sdo_i = 1'b0;
  logic        bclk_o, sdi_o, reg_wr_o;
  logic [6:0]  reg_addr_o;
  logic [15:0] reg_data_o, pcm_l_o, pcm_r_o;
  logic [15:0] pcm_l_i = 16'h0, pcm_r_i = 16'h0;

  aclink_codec u_aclink_codec (
    .clk(clk), .rst(rst), .sync_i(sync_i), .sdo_i(sdo_i), .bclk_o(bclk_o),
    .sdi_o(sdi_o), .reg_wr_o(reg_wr_o), .reg_addr_o(reg_addr_o),
    .reg_data_o(reg_data_o), .pcm_l_o(pcm_l_o), .pcm_r_o(pcm_r_o),
    .pcm_l_i(pcm_l_i), .pcm_r_i(pcm_r_i)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, wr_seen = 0;
  bit done = 0;
  logic [22:0] exp_q[$];
  logic [255:0] obs;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them (R3)
  always @(negedge clk) begin
    if (reg_wr_o === 1'b1) begin
      wr_seen++;
      if (exp_q.size() == 0) chk(0, "R3 unexpected write", {reg_addr_o, reg_data_o}, 0);
      else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        chk({reg_addr_o, reg_data_o} == e, "R3 write addr/data", {reg_addr_o, reg_data_o}, e);
      end
    end
  end

  function automatic logic [255:0] mk_frame(input logic [15:0] tag, input logic rd,
      input logic [6:0] addr, input logic [15:0] data, input logic [15:0] l, input logic [15:0] r);
    logic [255:0] f;
    logic [19:0] w;
    f = '0;
    for (int k = 0; k < 16; k++) f[k] = tag[15-k];
    for (int n = 1; n <= 4; n++) begin
      case (n)
        1: w = {rd, addr, 12'h0};
        2: w = {data, 4'h0};
        3: w = {l, 4'h0};
        default: w = {r, 4'h0};
      endcase
      for (int k = 0; k < 20; k++) f[16 + 20*(n-1) + k] = w[19-k];
    end
    return f;
  endfunction

  task automatic send(input logic [255:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      do @(negedge clk); while (bclk_o !== 1'b0);
      sync_i = (i < 16);
      sdo_i  = f[i];
      @(negedge clk);
      if (i > 0) obs[i-1] = sdi_o;
    end
    sdo_i = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic count_toggles(input int n, output int c);
    logic p;
    c = 0;
    p = bclk_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bclk_o !== p) c++;
      p = bclk_o;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int c, w0;
    logic [255:0] ef;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bclk_o === 0 && sdi_o === 0 && reg_wr_o === 0, "R1 outputs in reset", {bclk_o, sdi_o, reg_wr_o}, 0);
    chk(pcm_l_o === 0 && pcm_r_o === 0, "R1 samples in reset", {pcm_l_o, pcm_r_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R2 divide by two
    count_toggles(16, c);
    chk(c == 16, "R2 bclk toggles", c, 16);

    // frame A: valid write plus audio
    pcm_l_i = 16'hA5C3; pcm_r_i = 16'h1234;
    exp_q.push_back({7'h02, 16'h8080});
    send(mk_frame(16'hF800, 0, 7'h02, 16'h8080, 16'h1111, 16'h2222), 256);
    settle();
    chk(pcm_l_o == 16'h1111, "R5 left sample", pcm_l_o, 16'h1111);
    chk(pcm_r_o == 16'h2222, "R5 right sample", pcm_r_o, 16'h2222);
    ef = mk_frame(16'h9800, 0, 7'h0, 16'h0, 16'hA5C3, 16'h1234);
    chk(obs[91:0] == ef[91:0], "R6 outgoing frame", obs[31:0], ef[31:0]);
    chk(wr_seen == 1, "R3 write count", wr_seen, 1);

    // frame B: slot 1 marked invalid
    w0 = wr_seen;
    send(mk_frame(16'hB800, 0, 7'h04, 16'hDEAD, 16'h3333, 16'h4444), 256);
    settle();
    chk(wr_seen == w0, "R4 invalid slot1 no write", wr_seen, w0);
    chk(pcm_l_o == 16'h3333, "R5 left sample B", pcm_l_o, 16'h3333);

    // frame C: read command, slot 3 invalid
    send(mk_frame(16'hE800, 1, 7'h06, 16'hBEEF, 16'h5555, 16'h6666), 256);
    settle();
    chk(wr_seen == w0, "R4 read no write", wr_seen, w0);
    chk(pcm_l_o == 16'h3333, "R5 left held", pcm_l_o, 16'h3333);
    chk(pcm_r_o == 16'h6666, "R5 right updated", pcm_r_o, 16'h6666);

    // frame D: power register without the link-down bit
    exp_q.push_back({7'h20, 16'h0100});
    send(mk_frame(16'hF800, 0, 7'h20, 16'h0100, 16'h0, 16'h0), 256);
    count_toggles(10, c);
    chk(c == 10, "R7 link stays up", c, 10);

    // frame E: link-down write, frame cut after slot 2
    exp_q.push_back({7'h20, 16'h1000});
    send(mk_frame(16'hF800, 0, 7'h20, 16'h1000, 16'h0, 16'h0), 56);
    settle();
    c = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bclk_o !== 0 || sdi_o !== 0) c++;
    end
    chk(c == 0, "R7 bclk and sdi held low", c, 0);

    // R8 warm reset by frame marker pulse
    sync_i = 1'b1;
    c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk_o !== 0) c++;
    end
    chk(c == 0, "R8 stopped during pulse", c, 0);
    sync_i = 1'b0;
    @(negedge clk);
    count_toggles(20, c);
    chk(c >= 18, "R8 bclk restarted", c, 18);
    exp_q.push_back({7'h06, 16'h7777});
    send(mk_frame(16'hF800, 0, 7'h06, 16'h7777, 16'h0ABC, 16'h0DEF), 256);
    settle();
    chk(pcm_l_o == 16'h0ABC, "R8 decode after wake", pcm_l_o, 16'h0ABC);

    // R9 cold reset mid frame
    exp_q.push_back({7'h08, 16'h4242});
    send(mk_frame(16'hF800, 0, 7'h08, 16'h4242, 16'h9999, 16'h9999), 100);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bclk_o === 0 && sdi_o === 0, "R9 link low in reset", {bclk_o, sdi_o}, 0);
    chk(pcm_l_o === 0, "R9 samples cleared", pcm_l_o, 0);
    rst = 1'b0;
    exp_q.push_back({7'h0A, 16'h5A5A});
    send(mk_frame(16'hF800, 0, 7'h0A, 16'h5A5A, 16'h1357, 16'h2468), 256);
    settle();
    chk(pcm_l_o == 16'h1357 && pcm_r_o == 16'h2468, "R9 frame after reset", pcm_l_o, 16'h1357);
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    finish_up();
  end
endmodule